// File: doc/BRIEF.md
# Banked Program Memory Mapper

This block sits on the cartridge side of an 8-bit CPU bus and places a large program ROM behind a 32 KiB CPU window. The window is cut into four 8 KiB slots. Two slots follow bank numbers that software writes into registers, and the other two always show the last two banks of the ROM. A mode bit decides whether the first or the third slot holds the fixed second-to-last bank. The same block also controls an 8 KiB work-RAM window: software can turn RAM reads on or off and can block RAM writes.

Software programs the block by writing to the upper half of the address space. Address bits 14:13 pick one of four register ranges, and address bit 0 picks between the two registers in each range. The block translates each CPU address into a ROM byte address and a RAM enable. It then returns read data from the ROM, from the RAM, or as zero. The ROM and RAM arrays are outside the block. Their read data comes back in on `rom_rdata_i` and `ram_rdata_i`.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the two program bank registers hold 0, both mode bits are 0, mirroring is vertical (`mirror_horiz_o`=0), RAM reads are enabled and RAM writes are allowed.
- R2: A write with address bits 15:13 = 100 and bit 0 = 0 is a bank select. Data bits 2:0 name the target register (0..7), bit 6 is the program slot mode, and bit 7 is the graphics mode, which appears on `chr_mode_o`.
- R3: A write with address bits 15:13 = 100 and bit 0 = 1 stores the data byte into the register named by the last bank select. Only targets 6 and 7 affect program slots. Writes to targets 0..5 leave the program mapping unchanged.
- R4: With slot mode 0, slot 0x8000 uses register 6, slot 0xA000 uses register 7, slot 0xC000 uses bank ROM_BANKS-2, and slot 0xE000 uses bank ROM_BANKS-1.
- R5: With slot mode 1, slot 0x8000 uses bank ROM_BANKS-2 and slot 0xC000 uses register 6. Slots 0xA000 and 0xE000 are unchanged from mode 0.
- R6: `rom_addr_o` equals bank × 0x2000 plus address bits 12:0. Register values keep only their low log2(ROM_BANKS) bits, so out-of-range values wrap.
- R7: A write with address bits 15:13 = 101 and bit 0 = 0 sets `mirror_horiz_o` to data bit 0 (1 = horizontal). No other write changes it.
- R8: A write with address bits 15:13 = 101 and bit 0 = 1 sets RAM protection. Data bit 7 = 1 enables RAM reads, and data bit 6 = 1 blocks RAM writes. The RAM enables are active only for addresses 0x6000–0x7FFF.
- R9: A read returns `rom_rdata_i` for addresses 0x8000–0xFFFF and `ram_rdata_i` for RAM-window addresses when RAM reads are enabled. All other reads return 0.
- R10: Writes to 0xC000–0xFFFF and writes below 0x8000 change no mapping, mode or mirroring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | Write strobe, captured on the rising clock edge |
| rom_rdata_i | input | 8 | Data from program ROM |
| ram_rdata_i | input | 8 | Data from work RAM |
| rom_addr_o | output | log2(ROM_BANKS)+13 | Translated ROM byte address |
| ram_addr_o | output | 13 | Offset into work RAM |
| ram_rd_en_o | output | 1 | RAM read enable |
| ram_wr_en_o | output | 1 | RAM write enable |
| rdata_o | output | 8 | Read data returned to the CPU |
| mirror_horiz_o | output | 1 | Mirroring select, 1 = horizontal |
| chr_mode_o | output | 1 | Graphics bank mode bit |

## Verification
The bench swaps the slot mode back and forth and checks that the fixed bank moves between 0x8000 and 0xC000 while 0xA000 and 0xE000 stay put. A design that decoded the mode bit wrongly would show a register bank where the second-to-last bank belongs. It writes a register value above the bank count, which a design without masking would turn into an address past the ROM. It also sends data writes to targets 0..5 and writes into the interrupt ranges; a design that decoded these loosely would corrupt registers 6 and 7 or the mode. Finally it toggles the read-enable and write-block bits on their own, which exposes swapped protect bits or RAM data leaking onto the bus while RAM reads are disabled.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  // register range chosen by cpu address bits 14:13
  typedef enum logic [1:0] {
    WIN_BANK  = 2'd0,
    WIN_MIRR  = 2'd1,
    WIN_IRQ_A = 2'd2,
    WIN_IRQ_B = 2'd3
  } reg_win_e;

  typedef struct packed {
    logic       chr_mode;
    logic       prg_mode;
    logic [2:0] sel;
    logic       mirror_h;
    logic       ram_rd_on;
    logic       ram_wr_blk;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{
    chr_mode:   1'b0,
    prg_mode:   1'b0,
    sel:        3'd0,
    mirror_h:   1'b0,
    ram_rd_on:  1'b1,
    ram_wr_blk: 1'b0
  };

  // first bank data register that feeds the program slots
  localparam int PRG_REG_BASE = 6;
  localparam int PRG_REG_NUM  = 2;

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_win_e          win_i,
  input  logic              odd_i,
  input  logic [7:0]        wdata_i,
  output ctrl_t             ctrl_o,
  output logic [BANK_W-1:0] bank_a_o,
  output logic [BANK_W-1:0] bank_b_o
);

  ctrl_t             ctrl_q;
  logic [BANK_W-1:0] bank_q [PRG_REG_NUM];
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_i) begin
      unique case (win_i)
        WIN_BANK: if (!odd_i) begin
          ctrl_q.chr_mode <= wdata_i[7];
          ctrl_q.prg_mode <= wdata_i[6];
          ctrl_q.sel      <= wdata_i[2:0];
        end
        WIN_MIRR: if (!odd_i) begin
          ctrl_q.mirror_h <= wdata_i[0];
        end else begin
          ctrl_q.ram_rd_on  <= wdata_i[7];
          ctrl_q.ram_wr_blk <= wdata_i[6];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < PRG_REG_NUM; g++) begin : g_bank
    logic hit;
    assign hit = wr_i && (win_i == WIN_BANK) && odd_i &&
                 (ctrl_q.sel == 3'(PRG_REG_BASE + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  bank_q[g] <= '0;
      else if (hit) bank_q[g] <= wdata_i[BANK_W-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign bank_a_o = bank_q[0];
  assign bank_b_o = bank_q[1];

endmodule

// File: rtl/prg_slot_xlate.sv
module prg_slot_xlate #(
  parameter int ROM_BANKS = 32,
  parameter int BANK_W    = $clog2(ROM_BANKS)
) (
  input  logic               prg_mode_i,
  input  logic [BANK_W-1:0]  bank_a_i,
  input  logic [BANK_W-1:0]  bank_b_i,
  input  logic [14:0]        addr_i,
  output logic [BANK_W+12:0] rom_addr_o
);

  localparam logic [BANK_W-1:0] BANK_LAST   = BANK_W'(ROM_BANKS - 1);
  localparam logic [BANK_W-1:0] BANK_PENULT = BANK_W'(ROM_BANKS - 2);

  logic [BANK_W-1:0] bank;

  always_comb begin
    unique case (addr_i[14:13])
      2'd0:    bank = prg_mode_i ? BANK_PENULT : bank_a_i;
      2'd1:    bank = bank_b_i;
      2'd2:    bank = prg_mode_i ? bank_a_i : BANK_PENULT;
      default: bank = BANK_LAST;
    endcase
  end

  assign rom_addr_o = {bank, addr_i[12:0]};

endmodule

// File: rtl/prg_rd_mux.sv
module prg_rd_mux (
  input  logic       we_i,
  input  logic       rom_win_i,
  input  logic       ram_win_i,
  input  logic       ram_rd_on_i,
  input  logic       ram_wr_blk_i,
  input  logic [7:0] rom_rdata_i,
  input  logic [7:0] ram_rdata_i,
  output logic       ram_rd_en_o,
  output logic       ram_wr_en_o,
  output logic [7:0] rdata_o
);

  assign ram_rd_en_o = ram_win_i && !we_i && ram_rd_on_i;
  assign ram_wr_en_o = ram_win_i && we_i && !ram_wr_blk_i;

  always_comb begin
    if (rom_win_i)        rdata_o = rom_rdata_i;
    else if (ram_rd_en_o) rdata_o = ram_rdata_i;
    else                  rdata_o = 8'h00;
  end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ROM_BANKS = 32,
  localparam int BANK_W   = $clog2(ROM_BANKS),
  localparam int ROM_AW   = BANK_W + 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  input  logic              cpu_we_i,
  input  logic [7:0]        rom_rdata_i,
  input  logic [7:0]        ram_rdata_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [12:0]       ram_addr_o,
  output logic              ram_rd_en_o,
  output logic              ram_wr_en_o,
  output logic [7:0]        rdata_o,
  output logic              mirror_horiz_o,
  output logic              chr_mode_o
);

  ctrl_t             ctrl;
  logic [BANK_W-1:0] bank_a;
  logic [BANK_W-1:0] bank_b;
  logic              rom_win;
  logic              ram_win;
  reg_win_e          win;

  assign rom_win = cpu_addr_i[15];
  assign ram_win = (cpu_addr_i[15:13] == 3'b011);
  assign win     = reg_win_e'(cpu_addr_i[14:13]);

  prg_map_regs #(.BANK_W(BANK_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cpu_we_i && rom_win),
    .win_i    (win),
    .odd_i    (cpu_addr_i[0]),
    .wdata_i  (cpu_wdata_i),
    .ctrl_o   (ctrl),
    .bank_a_o (bank_a),
    .bank_b_o (bank_b)
  );

  prg_slot_xlate #(.ROM_BANKS(ROM_BANKS), .BANK_W(BANK_W)) u_xlate (
    .prg_mode_i (ctrl.prg_mode),
    .bank_a_i   (bank_a),
    .bank_b_i   (bank_b),
    .addr_i     (cpu_addr_i[14:0]),
    .rom_addr_o (rom_addr_o)
  );

  prg_rd_mux u_rd (
    .we_i         (cpu_we_i),
    .rom_win_i    (rom_win),
    .ram_win_i    (ram_win),
    .ram_rd_on_i  (ctrl.ram_rd_on),
    .ram_wr_blk_i (ctrl.ram_wr_blk),
    .rom_rdata_i  (rom_rdata_i),
    .ram_rdata_i  (ram_rdata_i),
    .ram_rd_en_o  (ram_rd_en_o),
    .ram_wr_en_o  (ram_wr_en_o),
    .rdata_o      (rdata_o)
  );

  assign ram_addr_o     = cpu_addr_i[12:0];
  assign mirror_horiz_o = ctrl.mirror_h;
  assign chr_mode_o     = ctrl.chr_mode;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int ROM_BANKS = 32,
  localparam int BANK_W   = $clog2(ROM_BANKS),
  localparam int ROM_AW   = BANK_W + 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic [7:0]        cpu_wdata_i,
  input logic              cpu_we_i,
  input logic [7:0]        rom_rdata_i,
  input logic [7:0]        ram_rdata_i,
  input logic [ROM_AW-1:0] rom_addr_o,
  input logic [12:0]       ram_addr_o,
  input logic              ram_rd_en_o,
  input logic              ram_wr_en_o,
  input logic [7:0]        rdata_o,
  input logic              mirror_horiz_o,
  input logic              chr_mode_o
);

  logic unused_chk;
  assign unused_chk = ^{cpu_wdata_i, ram_rdata_i, ram_addr_o};

  AST_ROM_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15] |-> rom_addr_o[12:0] == cpu_addr_i[12:0]); // R6

  AST_LAST_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15:13] == 3'b111 |-> rom_addr_o[ROM_AW-1:13] == {BANK_W{1'b1}}); // R4

  AST_ROM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15] |-> rdata_o == rom_rdata_i); // R9

  AST_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_addr_i[15] && !ram_rd_en_o) |-> rdata_o == 8'h00); // R9

  AST_RAM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_rd_en_o || ram_wr_en_o) |-> cpu_addr_i[15:13] == 3'b011); // R8

  AST_RAM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_rd_en_o && ram_wr_en_o)); // R8

  AST_MIRROR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mirror_horiz_o) |->
      $past(cpu_we_i && cpu_addr_i[15:13] == 3'b101 && !cpu_addr_i[0])); // R7

  AST_CHR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(chr_mode_o) |->
      $past(cpu_we_i && cpu_addr_i[15:13] == 3'b100 && !cpu_addr_i[0])); // R2

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.ROM_BANKS(ROM_BANKS)) u_chk (.*);

// File: tb/prg_bank_mapper_test.sv
module prg_bank_mapper_test;

  localparam int ROM_BANKS = 32;
  localparam int ROM_AW    = $clog2(ROM_BANKS) + 13;
  localparam logic [7:0] ROM_BYTE = 8'hA5;
  localparam logic [7:0] RAM_BYTE = 8'h3C;

  // kind: 0 write, 1 check rom address, 2 check read data, 3 write and check ram_wr_en
  localparam int NV = 34;
  localparam logic [53:0] VEC [NV] = '{
    {2'd0, 16'h8000, 8'h06, 24'h000000, 4'd2},   // R2 select 6
    {2'd0, 16'h8001, 8'h05, 24'h000000, 4'd3},   // R3
    {2'd0, 16'h8000, 8'h07, 24'h000000, 4'd2},   // R2 select 7
    {2'd0, 16'h8001, 8'h09, 24'h000000, 4'd3},   // R3
    {2'd1, 16'h8010, 8'h00, 24'h00A010, 4'd4},   // R4
    {2'd1, 16'hA004, 8'h00, 24'h012004, 4'd4},   // R4
    {2'd1, 16'hC000, 8'h00, 24'h03C000, 4'd4},   // R4
    {2'd1, 16'hFFFF, 8'h00, 24'h03FFFF, 4'd4},   // R4
    {2'd0, 16'h8000, 8'h46, 24'h000000, 4'd2},   // R2 mode 1
    {2'd1, 16'h8001, 8'h00, 24'h03C001, 4'd5},   // R5
    {2'd1, 16'hC002, 8'h00, 24'h00A002, 4'd5},   // R5
    {2'd1, 16'hA000, 8'h00, 24'h012000, 4'd5},   // R5
    {2'd1, 16'hE000, 8'h00, 24'h03E000, 4'd5},   // R5
    {2'd0, 16'h8001, 8'h27, 24'h000000, 4'd6},   // R6 wraps to 7
    {2'd1, 16'hC100, 8'h00, 24'h00E100, 4'd6},   // R6
    {2'd0, 16'h8000, 8'h40, 24'h000000, 4'd3},   // R3 select 0
    {2'd0, 16'h8001, 8'h1F, 24'h000000, 4'd3},   // R3
    {2'd1, 16'hC000, 8'h00, 24'h00E000, 4'd3},   // R3 reg 6 kept
    {2'd0, 16'hC000, 8'hFF, 24'h000000, 4'd10},  // R10
    {2'd0, 16'hE001, 8'h00, 24'h000000, 4'd10},  // R10
    {2'd1, 16'h8000, 8'h00, 24'h03C000, 4'd10},  // R10 mode kept
    {2'd2, 16'h8123, 8'h00, 24'h0000A5, 4'd9},   // R9
    {2'd2, 16'h5000, 8'h00, 24'h000000, 4'd9},   // R9
    {2'd2, 16'h6000, 8'h00, 24'h00003C, 4'd9},   // R9
    {2'd0, 16'hA001, 8'h00, 24'h000000, 4'd8},   // R8 reads off
    {2'd2, 16'h7FFF, 8'h00, 24'h000000, 4'd8},   // R8
    {2'd3, 16'h6000, 8'h11, 24'h000001, 4'd8},   // R8 writes still allowed
    {2'd0, 16'hA001, 8'hC0, 24'h000000, 4'd8},   // R8 reads on, writes blocked
    {2'd3, 16'h7000, 8'h22, 24'h000000, 4'd8},   // R8
    {2'd2, 16'h6000, 8'h00, 24'h00003C, 4'd8},   // R8
    {2'd0, 16'h7FFF, 8'h46, 24'h000000, 4'd10},  // R10 ram write, no register
    {2'd1, 16'hC000, 8'h00, 24'h00E000, 4'd10},  // R10
    {2'd0, 16'hA001, 8'h80, 24'h000000, 4'd8},   // R8
    {2'd3, 16'h6000, 8'h33, 24'h000001, 4'd8}    // R8
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [15:0]       cpu_addr_i = 16'h0;
  logic [7:0]        cpu_wdata_i = 8'h0;
  logic              cpu_we_i = 1'b0;
  logic [ROM_AW-1:0] rom_addr_o;
  logic [12:0]       ram_addr_o;
  logic              ram_rd_en_o;
  logic              ram_wr_en_o;
  logic [7:0]        rdata_o;
  logic              mirror_horiz_o;
  logic              chr_mode_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  prg_bank_mapper #(.ROM_BANKS(ROM_BANKS)) uut (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpu_addr_i     (cpu_addr_i),
    .cpu_wdata_i    (cpu_wdata_i),
    .cpu_we_i       (cpu_we_i),
    .rom_rdata_i    (ROM_BYTE),
    .ram_rdata_i    (RAM_BYTE),
    .rom_addr_o     (rom_addr_o),
    .ram_addr_o     (ram_addr_o),
    .ram_rd_en_o    (ram_rd_en_o),
    .ram_wr_en_o    (ram_wr_en_o),
    .rdata_o        (rdata_o),
    .mirror_horiz_o (mirror_horiz_o),
    .chr_mode_o     (chr_mode_o)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_we_i = 1'b1;
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_we_i = 1'b0;
    #1;
  endtask

  task automatic reset_checks();
    look(16'h8000); check("R1 slot0", 24'(rom_addr_o), 24'h000000);
    look(16'hA123); check("R1 slot1", 24'(rom_addr_o), 24'h000123);
    look(16'hC000); check("R1 slot2", 24'(rom_addr_o), 24'h03C000);
    check("R1 mirror", 24'(mirror_horiz_o), 24'h0);
    check("R1 chr", 24'(chr_mode_o), 24'h0);
    look(16'h6000); check("R1 ram read", 24'(rdata_o), 24'(RAM_BYTE));
    @(negedge clk_i);
    cpu_addr_i = 16'h6001; cpu_wdata_i = 8'h55; cpu_we_i = 1'b1;
    #1 check("R1 ram write", 24'(ram_wr_en_o), 24'h1);
    @(negedge clk_i);
    cpu_we_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    reset_checks();

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [15:0] a;
      logic [7:0]  d;
      logic [23:0] e;
      logic [3:0]  r;
      string       tag;
      {k, a, d, e, r} = VEC[i];
      tag = $sformatf("R%0d vec%0d", r, i);
      case (k)
        2'd0: wr(a, d);
        2'd1: begin look(a); check(tag, 24'(rom_addr_o), e); end
        2'd2: begin look(a); check(tag, 24'(rdata_o), e); end
        default: begin
          @(negedge clk_i);
          cpu_addr_i = a; cpu_wdata_i = d; cpu_we_i = 1'b1;
          #1 check(tag, 24'(ram_wr_en_o), e);
          @(negedge clk_i);
          cpu_we_i = 1'b0;
        end
      endcase
    end

    // R7 mirroring follows even writes only
    wr(16'hA000, 8'h01);
    check("R7 set", 24'(mirror_horiz_o), 24'h1);
    wr(16'hA001, 8'h80);
    check("R7 odd write", 24'(mirror_horiz_o), 24'h1);
    wr(16'hE000, 8'h00);
    check("R7 other range", 24'(mirror_horiz_o), 24'h1);
    wr(16'hA000, 8'hFE);
    check("R7 clear", 24'(mirror_horiz_o), 24'h0);

    // R2 graphics bit and slot mode from one select
    wr(16'h8000, 8'h80);
    check("R2 chr", 24'(chr_mode_o), 24'h1);
    look(16'h8000); check("R2 mode0", 24'(rom_addr_o), 24'h00E000);

    // R1 reset in mid-run restores defaults
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    reset_checks();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule